// File: doc/BRIEF.md
# Smart Card Character Receiver (T=0)

This block receives characters on the half-duplex smart card I/O line. Its time base is a half-ETU enable pulse supplied from outside, so every decision lands on a half-ETU boundary. The first half-tick on which the synchronised line is seen low while idle is count 0. From there the receiver checks that the start bit is still present, samples eight data bits and a parity bit at their ETU centres, and decodes the character in the convention in force. It then hands the byte to a receive FIFO through a write strobe.

When software arms TS detection, the next character is taken as the initial character. The receiver uses it to settle direct or inverse convention, stores the decoded TS, and disarms itself. A parity failure in T=0 mode makes the receiver pull the line low as an error signal, with a selectable length and a fixed start offset. After a clean character, the receiver samples the line once more to catch an error signal sent by the card.

The control FSM has eight states:
- IDLE waits for a low line.
- START checks the start bit.
- SHIFT collects the bits.
- EVAL judges parity and TS and writes the byte.
- PREBRK waits for the break slot.
- BREAK drives the line low.
- GUARD waits for the card-break sample.
- RECOVER waits for the line to go high.

Transitions:
- IDLE→START on a tick with the line low.
- START→IDLE on a false start.
- START→SHIFT on a valid start.
- SHIFT→EVAL after the parity sample.
- EVAL→PREBRK when a break is due.
- EVAL→GUARD otherwise.
- PREBRK→BREAK on the next tick.
- BREAK→RECOVER when the length has elapsed.
- GUARD→RECOVER after the card-break sample.
- RECOVER→IDLE once the line is high.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `line_low_o` is 0, `conv_direct_o` is 1 (direct), `ts_pending_o` is 0 and no strobe or flag output is high.
- R2: If the line is high again at count 1 (0.5 ETU), the receiver drops the character. No write and no flag follow, and it returns to IDLE.
- R3: Bit j of the frame (0 = start, 1..8 = data, 9 = parity) is sampled at count 2j+1. In direct convention, data bit i is the line level of frame bit i+1, with high meaning 1. A good character raises `wr_o` for one cycle with the byte on `data_o`.
- R4: In inverse convention, data bit 7-i is the inverted line level of frame bit i+1. The data travels MSB first and a low line means 1.
- R5: Parity is good when the number of high levels among the eight data bits and the parity bit is even. A bad parity pulses `par_err_o` unless `par_dis_i` is 1.
- R6: On bad parity with `proto_t0_i`=1, `brk_en_i`=1 and `par_dis_i`=0, `line_low_o` rises at count 21 (10.5 ETU) and the character is not written. Under any other setting of these three inputs the line is never driven.
- R7: The break length set by `brk_len_i` is 2'b00: 2 half-ETUs, 2'b01: 3, 2'b10: 4, and 2'b11: 2.
- R8: Bad parity without a break (break disabled, or not T=0) still writes the byte and pulses `par_err_o`.
- R9: When no break was driven, the line is sampled at count 22 (11 ETU). A low level pulses `card_brk_o`.
- R10: With `ts_pending_o` set, a line pattern that reads 0x3B in direct order sets `conv_direct_o` to 1 and writes 0x3B. A pattern that reads 0x03 in direct order sets `conv_direct_o` to 0 and writes 0x3F. In both cases `ts_pending_o` clears. A pulse on `ts_arm_i` sets `ts_pending_o`.
- R11: A pending TS that matches neither pattern pulses `ts_bad_o`, writes nothing, leaves `conv_direct_o` unchanged and clears `ts_pending_o`.
- R12: A pulse on `conv_wr_i` loads `conv_direct_o` from `conv_wdata_i`.
- R13: If `fifo_full_i` is high when a byte would be written, `ovr_o` pulses and `wr_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick_i | input | 1 | One-cycle enable at twice the ETU rate |
| line_i | input | 1 | Smart card I/O line level |
| proto_t0_i | input | 1 | 1 = T=0 mode |
| par_dis_i | input | 1 | 1 = parity check disabled |
| brk_en_i | input | 1 | 1 = error break allowed |
| brk_len_i | input | 2 | Break length code |
| ts_arm_i | input | 1 | Pulse: treat next character as TS |
| conv_wr_i | input | 1 | Pulse: load convention bit |
| conv_wdata_i | input | 1 | Convention value to load |
| fifo_full_i | input | 1 | Receive FIFO full |
| line_low_o | output | 1 | Drive line low (error break) |
| wr_o | output | 1 | Byte write strobe |
| data_o | output | 8 | Decoded byte |
| conv_direct_o | output | 1 | 1 = direct, 0 = inverse |
| ts_pending_o | output | 1 | TS detection armed |
| par_err_o | output | 1 | Parity error pulse |
| ts_bad_o | output | 1 | Invalid TS pulse |
| ovr_o | output | 1 | Overrun pulse |
| card_brk_o | output | 1 | Card break pulse |

## Verification
The assertions assume that `brk_len_i`, `brk_en_i`, `par_dis_i`, `proto_t0_i` and `fifo_full_i` are steady during a character. The break-length, break-gating and full-FIFO properties compare against those inputs as they stand when the output moves. The stimulus changes these controls only between characters, while the line has been idle for several half-ETUs. It also lets `half_tick_i` arrive at least three clocks after every line change, so the synchroniser has settled before each sample.

// File: rtl/sc_char_rx_pkg.sv
package sc_char_rx_pkg;

    localparam int RX_DATA_W = 8;

    // Line patterns read in direct bit order
    localparam logic [RX_DATA_W-1:0] TS_LINE_DIRECT  = 8'h3B;
    localparam logic [RX_DATA_W-1:0] TS_LINE_INVERSE = 8'h03;
    // Byte stored for an inverse-convention TS
    localparam logic [RX_DATA_W-1:0] TS_BYTE_INVERSE = 8'h3F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_EVAL,
        ST_PREBRK,
        ST_BREAK,
        ST_GUARD,
        ST_RECOVER
    } rx_state_e;

endpackage

// File: rtl/sc_char_rx_shift.sv
module sc_char_rx_shift #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    // First bit shifted in ends at word_o[0]
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (en_i) begin
            word_o <= {bit_i, word_o[WORD_W-1:1]};
        end
    end
endmodule

// File: rtl/sc_char_rx_decode.sv
module sc_char_rx_decode
    import sc_char_rx_pkg::*;
(
    input  logic [RX_DATA_W:0]   raw_i,
    output logic [RX_DATA_W-1:0] byte_dir_o,
    output logic [RX_DATA_W-1:0] byte_inv_o,
    output logic                 par_odd_o,
    output logic                 ts_dir_o,
    output logic                 ts_inv_o
);
    genvar gi;
    generate
        for (gi = 0; gi < RX_DATA_W; gi++) begin : g_bit
            assign byte_dir_o[gi]               = raw_i[gi];
            assign byte_inv_o[RX_DATA_W-1-gi]   = ~raw_i[gi];
        end
    endgenerate

    // Even count of high levels over data plus parity is good
    assign par_odd_o = ^raw_i;
    assign ts_dir_o  = (raw_i[RX_DATA_W-1:0] == TS_LINE_DIRECT);
    assign ts_inv_o  = (raw_i[RX_DATA_W-1:0] == TS_LINE_INVERSE);
endmodule

// File: rtl/sc_char_rx_brklen.sv
module sc_char_rx_brklen #(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       code_i,
    output logic [CNT_W-1:0] len_o
);
    // Length in half-ETUs; the reserved code falls back to one ETU
    always_comb begin
        unique case (code_i)
            2'b01:   len_o = CNT_W'(3);
            2'b10:   len_o = CNT_W'(4);
            default: len_o = CNT_W'(2);
        endcase
    end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_char_rx_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 half_tick_i,
    input  logic                 line_i,
    input  logic                 proto_t0_i,
    input  logic                 par_dis_i,
    input  logic                 brk_en_i,
    input  logic [1:0]           brk_len_i,
    input  logic                 ts_arm_i,
    input  logic                 conv_wr_i,
    input  logic                 conv_wdata_i,
    input  logic                 fifo_full_i,
    output logic                 line_low_o,
    output logic                 wr_o,
    output logic [RX_DATA_W-1:0] data_o,
    output logic                 conv_direct_o,
    output logic                 ts_pending_o,
    output logic                 par_err_o,
    output logic                 ts_bad_o,
    output logic                 ovr_o,
    output logic                 card_brk_o
);
    localparam int WORD_W  = RX_DATA_W + 1;
    localparam int PAR_AT  = 2 * RX_DATA_W + 3;
    localparam int EVAL_AT = PAR_AT + 1;
    localparam int BRK_AT  = PAR_AT + 2;
    localparam int CB_AT   = PAR_AT + 3;

    // ---------------- line synchroniser ----------------
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            end
        end
    endgenerate
    assign line_s = sync_q[SYNC_STAGES-1];

    // ---------------- half-ETU counter ----------------
    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    assign nxt = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (half_tick_i) begin
            if (state_q == ST_IDLE) cnt_q <= '0;
            else                    cnt_q <= nxt;
        end
    end

    // ---------------- datapath submodules ----------------
    logic              shift_en;
    logic [WORD_W-1:0] raw;
    logic [RX_DATA_W-1:0] byte_dir, byte_inv;
    logic              par_odd, ts_dir, ts_inv;
    logic [CNT_W-1:0]  brk_len;

    assign shift_en = (state_q == ST_SHIFT) && half_tick_i && nxt[0];

    sc_char_rx_shift #(.WORD_W(WORD_W)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (shift_en),
        .bit_i  (line_s),
        .word_o (raw)
    );

    sc_char_rx_decode i_decode (
        .raw_i      (raw),
        .byte_dir_o (byte_dir),
        .byte_inv_o (byte_inv),
        .par_odd_o  (par_odd),
        .ts_dir_o   (ts_dir),
        .ts_inv_o   (ts_inv)
    );

    sc_char_rx_brklen #(.CNT_W(CNT_W)) i_brklen (
        .code_i (brk_len_i),
        .len_o  (brk_len)
    );

    // ---------------- evaluation decisions ----------------
    logic                 par_bad, do_brk, brk_end;
    logic                 eval_tick;
    logic                 push_req;
    logic [RX_DATA_W-1:0] push_byte;
    logic                 ts_take, ts_fail;

    assign par_bad   = par_odd && !par_dis_i;
    assign do_brk    = par_bad && proto_t0_i && brk_en_i;
    assign eval_tick = (state_q == ST_EVAL) && half_tick_i;
    assign brk_end   = half_tick_i && (nxt == CNT_W'(BRK_AT) + brk_len);

    always_comb begin
        push_req  = 1'b0;
        push_byte = byte_dir;
        ts_take   = 1'b0;
        ts_fail   = 1'b0;
        if (eval_tick && !do_brk) begin
            if (ts_pending_o) begin
                if (ts_dir) begin
                    ts_take   = 1'b1;
                    push_req  = 1'b1;
                    push_byte = TS_LINE_DIRECT;
                end else if (ts_inv) begin
                    ts_take   = 1'b1;
                    push_req  = 1'b1;
                    push_byte = TS_BYTE_INVERSE;
                end else begin
                    ts_fail   = 1'b1;
                end
            end else begin
                push_req  = 1'b1;
                push_byte = conv_direct_o ? byte_dir : byte_inv;
            end
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (half_tick_i && !line_s) state_d = ST_START;
            end
            ST_START: begin
                if (half_tick_i) state_d = line_s ? ST_IDLE : ST_SHIFT;
            end
            ST_SHIFT: begin
                if (half_tick_i && (nxt == CNT_W'(PAR_AT))) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (half_tick_i) state_d = do_brk ? ST_PREBRK : ST_GUARD;
            end
            ST_PREBRK: begin
                if (half_tick_i) state_d = ST_BREAK;
            end
            ST_BREAK: begin
                if (brk_end) state_d = ST_RECOVER;
            end
            ST_GUARD: begin
                if (half_tick_i && (nxt == CNT_W'(CB_AT))) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (line_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_low_o    <= 1'b0;
            wr_o          <= 1'b0;
            data_o        <= '0;
            conv_direct_o <= 1'b1;
            ts_pending_o  <= 1'b0;
            par_err_o     <= 1'b0;
            ts_bad_o      <= 1'b0;
            ovr_o         <= 1'b0;
            card_brk_o    <= 1'b0;
        end else begin
            wr_o       <= 1'b0;
            par_err_o  <= 1'b0;
            ts_bad_o   <= 1'b0;
            ovr_o      <= 1'b0;
            card_brk_o <= 1'b0;

            if (eval_tick) par_err_o <= par_bad;

            if (push_req) begin
                if (fifo_full_i) begin
                    ovr_o <= 1'b1;
                end else begin
                    wr_o   <= 1'b1;
                    data_o <= push_byte;
                end
            end

            if (ts_take) begin
                conv_direct_o <= ts_dir;
                ts_pending_o  <= 1'b0;
            end
            if (ts_fail) begin
                ts_bad_o     <= 1'b1;
                ts_pending_o <= 1'b0;
            end

            if ((state_q == ST_PREBRK) && half_tick_i) begin
                line_low_o <= 1'b1;
            end else if ((state_q == ST_BREAK) && brk_end) begin
                line_low_o <= 1'b0;
            end

            if ((state_q == ST_GUARD) && half_tick_i &&
                (nxt == CNT_W'(CB_AT)) && !line_s) begin
                card_brk_o <= 1'b1;
            end

            if (ts_arm_i)  ts_pending_o  <= 1'b1;
            if (conv_wr_i) conv_direct_o <= conv_wdata_i;
        end
    end
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       half_tick_i,
    input logic       proto_t0_i,
    input logic       par_dis_i,
    input logic       brk_en_i,
    input logic [1:0] brk_len_i,
    input logic       fifo_full_i,
    input logic       line_low_o,
    input logic       wr_o,
    input logic       par_err_o,
    input logic       ts_bad_o,
    input logic       ovr_o,
    input logic       card_brk_o
);
    // Half-ETUs elapsed while the line is driven low
    logic [3:0] low_ticks;
    logic [3:0] want_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           low_ticks <= '0;
        else if (!line_low_o) low_ticks <= '0;
        else if (half_tick_i) low_ticks <= low_ticks + 4'd1;
    end

    assign want_len = (brk_len_i == 2'b01) ? 4'd3 :
                      (brk_len_i == 2'b10) ? 4'd4 : 4'd2;

    a_r7_break_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_low_o) |-> (low_ticks == want_len));

    a_r6_break_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_low_o) |-> (proto_t0_i && brk_en_i && !par_dis_i));

    a_r6_no_write_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        line_low_o |-> !wr_o);

    a_r13_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_full_i) |-> !wr_o);

    a_r5_err_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |=> !par_err_o);

    a_r11_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_o, ts_bad_o, ovr_o}));

    a_r9_card_brk_not_own: assert property (@(posedge clk) disable iff (!rst_n)
        card_brk_o |-> !line_low_o);
endmodule

bind sc_char_rx sc_char_rx_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_tick_i (half_tick_i),
    .proto_t0_i  (proto_t0_i),
    .par_dis_i   (par_dis_i),
    .brk_en_i    (brk_en_i),
    .brk_len_i   (brk_len_i),
    .fifo_full_i (fifo_full_i),
    .line_low_o  (line_low_o),
    .wr_o        (wr_o),
    .par_err_o   (par_err_o),
    .ts_bad_o    (ts_bad_o),
    .ovr_o       (ovr_o),
    .card_brk_o  (card_brk_o)
);

// File: tb/test_sc_char_rx.sv
`timescale 1ns/1ps
module test_sc_char_rx;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       card = 1'b1;
    logic       line;
    logic       proto_t0 = 1'b1, par_dis = 1'b0, brk_en = 1'b1;
    logic [1:0] brk_len = 2'b00;
    logic       ts_arm = 1'b0, conv_wr = 1'b0, conv_wdata = 1'b0, fifo_full = 1'b0;
    logic       line_low, wr, conv_direct, ts_pending, par_err, ts_bad, ovr, card_brk;
    logic [7:0] data;

    assign line = card & ~line_low;

    sc_char_rx i_sc_char_rx (
        .clk(clk), .rst_n(rst_n), .half_tick_i(half_tick), .line_i(line),
        .proto_t0_i(proto_t0), .par_dis_i(par_dis), .brk_en_i(brk_en),
        .brk_len_i(brk_len), .ts_arm_i(ts_arm), .conv_wr_i(conv_wr),
        .conv_wdata_i(conv_wdata), .fifo_full_i(fifo_full),
        .line_low_o(line_low), .wr_o(wr), .data_o(data),
        .conv_direct_o(conv_direct), .ts_pending_o(ts_pending),
        .par_err_o(par_err), .ts_bad_o(ts_bad), .ovr_o(ovr), .card_brk_o(card_brk)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int tcnt = 0;
    always @(posedge clk) if (half_tick) tcnt <= tcnt + 1;

    // Event monitor
    int n_wr = 0, n_pe = 0, n_tb = 0, n_ovr = 0, n_cb = 0, n_brk = 0;
    int t_rise = 0, t_fall = 0;
    logic [7:0] last_data = 8'h00;
    logic prev_ll = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (wr) begin n_wr++; last_data = data; end
        if (par_err)  n_pe++;
        if (ts_bad)   n_tb++;
        if (ovr)      n_ovr++;
        if (card_brk) n_cb++;
        if (line_low && !prev_ll) begin n_brk++; t_rise = tcnt; end
        if (!line_low && prev_ll) t_fall = tcnt;
        prev_ll = line_low;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic step();
        repeat (3) @(negedge clk);
        half_tick = 1'b1;
        @(negedge clk);
        half_tick = 1'b0;
    endtask

    function automatic logic [8:0] enc(input logic [7:0] d, input bit direct);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = direct ? d[i] : ~d[7-i];
        return {^r, r};
    endfunction

    task automatic send(input logic [8:0] raw, input bit cb, output int t0);
        t0 = tcnt + 1;
        card = 1'b0; step(); step();
        for (int j = 0; j < 9; j++) begin card = raw[j]; step(); step(); end
        card = ~cb; repeat (6) step();
        card = 1'b1; repeat (4) step();
    endtask

    // One character with expected deltas
    task automatic run(input string req, input logic [8:0] raw, input bit cb,
                       input int e_wr, input logic [7:0] e_data, input int e_pe,
                       input int e_brk, input int e_len, input int e_cb,
                       input int e_tb, input int e_ovr);
        int w0, p0, b0, c0, tb0, o0, t0;
        w0 = n_wr; p0 = n_pe; b0 = n_brk; c0 = n_cb; tb0 = n_tb; o0 = n_ovr;
        send(raw, cb, t0);
        chk(n_wr - w0 == e_wr, {req, " write count"}, n_wr - w0, e_wr);
        if (e_wr == 1) chk(last_data == e_data, {req, " data"}, last_data, e_data);
        chk(n_pe - p0 == e_pe, {req, " parity flag"}, n_pe - p0, e_pe);
        chk(n_brk - b0 == e_brk, {req, " break count"}, n_brk - b0, e_brk);
        if (e_brk == 1) begin
            chk(t_rise - t0 == 21, {req, " break start"}, t_rise - t0, 21);
            chk(t_fall - t_rise == e_len, {req, " break length"}, t_fall - t_rise, e_len);
        end
        chk(n_cb - c0 == e_cb, {req, " card break"}, n_cb - c0, e_cb);
        chk(n_tb - tb0 == e_tb, {req, " bad TS"}, n_tb - tb0, e_tb);
        chk(n_ovr - o0 == e_ovr, {req, " overrun"}, n_ovr - o0, e_ovr);
    endtask

    task automatic pulse_arm();
        @(negedge clk); ts_arm = 1'b1; @(negedge clk); ts_arm = 1'b0; @(negedge clk);
    endtask

    task automatic write_conv(input bit v);
        @(negedge clk); conv_wr = 1'b1; conv_wdata = v;
        @(negedge clk); conv_wr = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] r;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(line_low == 0, "R1 line_low", line_low, 0);
        chk(conv_direct == 1, "R1 conv default direct (R12)", conv_direct, 1);
        chk(ts_pending == 0, "R1 ts_pending", ts_pending, 0);
        chk({wr, par_err, ts_bad, ovr, card_brk} == 0, "R1 strobes", {wr, par_err, ts_bad, ovr, card_brk}, 0);
        rst_n = 1'b1;
        repeat (4) step();

        // R2 false start
        begin
            int w0, p0;
            w0 = n_wr; p0 = n_pe;
            card = 1'b0; step(); card = 1'b1; repeat (30) step();
            chk(n_wr == w0, "R2 no write on glitch", n_wr - w0, 0);
            chk(n_pe == p0, "R2 no flag on glitch", n_pe - p0, 0);
        end
        // R2 receiver still works after the false start
        run("R2 recovery", enc(8'h5A, 1), 0, 1, 8'h5A, 0, 0, 0, 0, 0, 0);

        // R3 direct sweep
        for (int d = 0; d < 256; d++)
            run("R3 direct", enc(8'(d), 1), 0, 1, 8'(d), 0, 0, 0, 0, 0, 0);

        // R6/R7 break on parity error, every length code
        for (int c = 0; c < 4; c++) begin
            brk_len = 2'(c);
            r = enc(8'hA5, 1); r[8] = ~r[8];
            run("R6 R7 break", r, 0, 0, 8'h00, 1, 1, (c == 1) ? 3 : (c == 2) ? 4 : 2, 0, 0, 0);
        end
        brk_len = 2'b00;

        // R8 break disabled: byte kept, flag raised
        r = enc(8'h3C, 1); r[8] = ~r[8];
        brk_en = 1'b0;
        run("R8 no break when disabled", r, 0, 1, 8'h3C, 1, 0, 0, 0, 0, 0);
        brk_en = 1'b1; proto_t0 = 1'b0;
        run("R8 no break outside T=0", r, 0, 1, 8'h3C, 1, 0, 0, 0, 0, 0);
        proto_t0 = 1'b1; par_dis = 1'b1;
        run("R5 parity disabled", r, 0, 1, 8'h3C, 0, 0, 0, 0, 0, 0);
        par_dis = 1'b0;

        // R9 card break
        run("R9 card break", enc(8'h81, 1), 1, 1, 8'h81, 0, 0, 0, 1, 0, 0);

        // R13 overrun
        fifo_full = 1'b1;
        run("R13 overrun", enc(8'h42, 1), 0, 0, 8'h00, 0, 0, 0, 0, 0, 1);
        fifo_full = 1'b0;

        // R10 TS direct
        pulse_arm();
        chk(ts_pending == 1, "R10 arm", ts_pending, 1);
        run("R10 TS direct", {1'b1, 8'h3B}, 0, 1, 8'h3B, 0, 0, 0, 0, 0, 0);
        chk(conv_direct == 1, "R10 conv direct", conv_direct, 1);
        chk(ts_pending == 0, "R10 pending cleared", ts_pending, 0);

        // R10 TS inverse
        write_conv(1'b1);
        pulse_arm();
        run("R10 TS inverse", {1'b0, 8'h03}, 0, 1, 8'h3F, 0, 0, 0, 0, 0, 0);
        chk(conv_direct == 0, "R10 conv inverse", conv_direct, 0);
        chk(ts_pending == 0, "R10 pending cleared inv", ts_pending, 0);

        // R4 inverse sweep
        for (int d = 0; d < 256; d++)
            run("R4 inverse", enc(8'(d), 0), 0, 1, 8'(d), 0, 0, 0, 0, 0, 0);

        // R11 invalid TS
        pulse_arm();
        run("R11 bad TS", {1'b0, 8'h55}, 0, 0, 8'h00, 0, 0, 0, 0, 1, 0);
        chk(conv_direct == 0, "R11 conv unchanged", conv_direct, 0);
        chk(ts_pending == 0, "R11 pending cleared", ts_pending, 0);

        // R12 software write
        write_conv(1'b1);
        chk(conv_direct == 1, "R12 conv write", conv_direct, 1);
        run("R12 direct after write", enc(8'hC3, 1), 0, 1, 8'hC3, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule